// File: doc/BRIEF.md
# Program Counter Sequencer with Conditional Branch Resolution

This block holds the program counter of a small processor core and chooses its next value every cycle. A decoder presents one instruction descriptor per cycle: a byte length, an operation class, a four-bit branch condition, a register index and a destination value. The block advances the PC past an ordinary instruction by that instruction's own length. A jump loads the destination value straight into the PC. A conditional branch is resolved against four condition flags held inside the block. Because the PC is also general register 15, a register write aimed at index 15 redirects flow exactly as a jump does.

The flags are N (negative), Z (zero), V (signed overflow) and C (carry out or borrow in at the top bit). An external arithmetic unit supplies them through a write-enabled port. A compare is modelled as a flag write with no result, so a branch that follows it sees the comparison outcome. Every taken jump, branch or register-15 write raises a one-cycle redirect strobe, which fetch logic uses to discard work already in flight.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is `pc` = `RESET_VEC`, `flags` = 0 and `redirect` = 0.
- R2: With `op_class` = 0 (sequential), the next `pc` is the current `pc` plus `instr_len`, and `redirect` goes low.
- R3: With `op_class` = 1 (jump), the next `pc` equals `dest`, and `redirect` is high for that cycle.
- R4: With `op_class` = 3 (register write), `reg_idx` = 15 behaves exactly like a jump to `dest`. Any other index advances `pc` by `instr_len` and leaves `redirect` low.
- R5: With `op_class` = 2 (branch), the signed condition codes are taken as follows: 0 when Z=1, 1 when Z=0, 2 when N=1, 3 when N|Z=1, 4 when N|Z=0 and 5 when N=0. V plays no part in any of them.
- R6: The unsigned condition codes are taken as follows: 8 when Z=1, 9 when Z=0, 10 when C=1, 11 when C|Z=1, 12 when C|Z=0 and 13 when C=0.
- R7: Condition codes 6, 7, 14 and 15 are never taken, whatever the flags.
- R8: A taken branch loads `dest` into `pc` and raises `redirect`. A branch that is not taken advances `pc` by `instr_len` with `redirect` low.
- R9: `flags` (bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C) load `flag_in` only on an edge where `flag_we` = 1 and otherwise hold. A branch in the same cycle as a flag write is resolved on the flags from before the write.
- R10: `redirect` is high for exactly one cycle per taken transfer. It falls on the following cycle unless that cycle also transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_len | input | LEN_W | Byte length of the current instruction |
| op_class | input | 2 | 0 sequential, 1 jump, 2 conditional branch, 3 register write |
| cond_code | input | 4 | Branch condition selector |
| reg_idx | input | RIDX_W | Destination register index for a register write |
| dest | input | AW | Jump or branch target, or register write value |
| flag_we | input | 1 | Load the condition flags from `flag_in` |
| flag_in | input | 4 | New flags {N,Z,V,C} from the arithmetic unit |
| pc | output | AW | Registered program counter |
| redirect | output | 1 | Registered one-cycle strobe on a taken transfer |
| flags | output | 4 | Registered condition flags {N,Z,V,C} |

## Verification
Every result of this block is due one clock edge after the descriptor is applied. That holds for `pc`, `redirect` and `flags`. The bench changes inputs just after a rising edge and reads the outputs just after the next rising edge, so each check covers exactly one descriptor. The condition table first loads the flags with a zero-length sequential step and then issues the branch on the following edge. The expected PC is computed from the PC value read before the branch. The same-cycle test drives a flag write and a branch together. It expects the branch to resolve on the old flags and the new flags to appear on the same edge.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  typedef enum logic [1:0] {
    OP_SEQ    = 2'd0,
    OP_JUMP   = 2'd1,
    OP_BRANCH = 2'd2,
    OP_REGWR  = 2'd3
  } op_class_e;

  // flag vector bit positions {N,Z,V,C}
  localparam int FLG_N = 3;
  localparam int FLG_Z = 2;
  localparam int FLG_V = 1;
  localparam int FLG_C = 0;
  localparam int FLG_W = 4;

  // condition field: bit 3 picks the unsigned group, low bits the relation
  localparam logic [2:0] REL_EQ = 3'd0;
  localparam logic [2:0] REL_NE = 3'd1;
  localparam logic [2:0] REL_LT = 3'd2;
  localparam logic [2:0] REL_LE = 3'd3;
  localparam logic [2:0] REL_GT = 3'd4;
  localparam logic [2:0] REL_GE = 3'd5;

endpackage

// File: rtl/pcseq_cond_eval.sv
module pcseq_cond_eval
  import pcseq_pkg::*;
(
  input  logic [FLG_W-1:0] flags,
  input  logic [3:0]       cond,
  output logic             taken
);
  logic less_bit;

  // signed group tests N alone; unsigned group substitutes C
  always_comb begin
    less_bit = cond[3] ? flags[FLG_C] : flags[FLG_N];
    unique case (cond[2:0])
      REL_EQ:  taken = flags[FLG_Z];
      REL_NE:  taken = ~flags[FLG_Z];
      REL_LT:  taken = less_bit;
      REL_LE:  taken = less_bit | flags[FLG_Z];
      REL_GT:  taken = ~(less_bit | flags[FLG_Z]);
      REL_GE:  taken = ~less_bit;
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/pcseq_flag_reg.sv
module pcseq_flag_reg
  import pcseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [FLG_W-1:0] d,
  output logic [FLG_W-1:0] q
);
  for (genvar b = 0; b < FLG_W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)     q[b] <= 1'b0;
      else if (we) q[b] <= d[b];
    end
  end
endmodule

// File: rtl/pcseq_next_sel.sv
module pcseq_next_sel
  import pcseq_pkg::*;
#(
  parameter int AW       = 32,
  parameter int LEN_W    = 4,
  parameter int RIDX_W   = 4,
  parameter int PC_INDEX = 15
) (
  input  logic [AW-1:0]     pc_cur,
  input  logic [LEN_W-1:0]  len,
  input  op_class_e         op,
  input  logic [RIDX_W-1:0] idx,
  input  logic [AW-1:0]     dest,
  input  logic              cond_taken,
  output logic [AW-1:0]     pc_nxt,
  output logic              xfer
);
  localparam logic [RIDX_W-1:0] PC_IDX = RIDX_W'(PC_INDEX);

  logic [AW-1:0] pc_fall;

  assign pc_fall = pc_cur + AW'(len);

  always_comb begin
    unique case (op)
      OP_JUMP:   xfer = 1'b1;
      OP_BRANCH: xfer = cond_taken;
      OP_REGWR:  xfer = (idx == PC_IDX);
      default:   xfer = 1'b0;
    endcase
    pc_nxt = xfer ? dest : pc_fall;
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcseq_pkg::*;
#(
  parameter int          AW        = 32,
  parameter int          LEN_W     = 4,
  parameter int          RIDX_W    = 4,
  parameter int          PC_INDEX  = 15,
  parameter logic [31:0] RESET_VEC = 32'h0000_0200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LEN_W-1:0]  instr_len,
  input  logic [1:0]        op_class,
  input  logic [3:0]        cond_code,
  input  logic [RIDX_W-1:0] reg_idx,
  input  logic [AW-1:0]     dest,
  input  logic              flag_we,
  input  logic [3:0]        flag_in,
  output logic [AW-1:0]     pc,
  output logic              redirect,
  output logic [3:0]        flags
);
  localparam logic [AW-1:0] RST_PC = AW'(RESET_VEC);

  logic          cond_taken;
  logic [AW-1:0] pc_nxt;
  logic          xfer;

  pcseq_flag_reg u_flags (
    .clk (clk),
    .rst (rst),
    .we  (flag_we),
    .d   (flag_in),
    .q   (flags)
  );

  pcseq_cond_eval u_cond (
    .flags (flags),
    .cond  (cond_code),
    .taken (cond_taken)
  );

  pcseq_next_sel #(
    .AW       (AW),
    .LEN_W    (LEN_W),
    .RIDX_W   (RIDX_W),
    .PC_INDEX (PC_INDEX)
  ) u_next (
    .pc_cur     (pc),
    .len        (instr_len),
    .op         (op_class_e'(op_class)),
    .idx        (reg_idx),
    .dest       (dest),
    .cond_taken (cond_taken),
    .pc_nxt     (pc_nxt),
    .xfer       (xfer)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= RST_PC;
      redirect <= 1'b0;
    end else begin
      pc       <= pc_nxt;
      redirect <= xfer;
    end
  end
endmodule

// File: rtl/pcseq_checker.sv
module pcseq_checker #(
  parameter int          AW        = 32,
  parameter int          LEN_W     = 4,
  parameter int          RIDX_W    = 4,
  parameter int          PC_INDEX  = 15,
  parameter logic [31:0] RESET_VEC = 32'h0000_0200
) (
  input logic              clk,
  input logic              rst,
  input logic [LEN_W-1:0]  instr_len,
  input logic [1:0]        op_class,
  input logic [3:0]        cond_code,
  input logic [RIDX_W-1:0] reg_idx,
  input logic [AW-1:0]     dest,
  input logic              flag_we,
  input logic [3:0]        flag_in,
  input logic [AW-1:0]     pc,
  input logic              redirect,
  input logic [3:0]        flags
);
  localparam logic [RIDX_W-1:0] PC_IDX = RIDX_W'(PC_INDEX);

  logic cc_unused;
  assign cc_unused = (cond_code[2:1] == 2'b11);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (pc == AW'(RESET_VEC) && flags == 4'd0 && !redirect));

  assert_seq_advance_R2: assert property (@(posedge clk) disable iff (rst)
    op_class == 2'd0 |=> (pc == $past(pc) + AW'($past(instr_len)) && !redirect));

  assert_jump_load_R3: assert property (@(posedge clk) disable iff (rst)
    op_class == 2'd1 |=> (pc == $past(dest) && redirect));

  assert_pc_regwrite_R4: assert property (@(posedge clk) disable iff (rst)
    (op_class == 2'd3 && reg_idx == PC_IDX) |=> (pc == $past(dest) && redirect));

  assert_other_regwrite_R4: assert property (@(posedge clk) disable iff (rst)
    (op_class == 2'd3 && reg_idx != PC_IDX) |=> (pc == $past(pc) + AW'($past(instr_len)) && !redirect));

  assert_unused_never_R7: assert property (@(posedge clk) disable iff (rst)
    (op_class == 2'd2 && cc_unused) |=> (!redirect && pc == $past(pc) + AW'($past(instr_len))));

  assert_branch_target_R8: assert property (@(posedge clk) disable iff (rst)
    (op_class == 2'd2) |=> (redirect ? (pc == $past(dest)) : (pc == $past(pc) + AW'($past(instr_len)))));

  assert_flags_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !flag_we |=> $stable(flags));

  assert_flags_load_R9: assert property (@(posedge clk) disable iff (rst)
    flag_we |=> flags == $past(flag_in));

  assert_strobe_drop_R10: assert property (@(posedge clk) disable iff (rst)
    op_class == 2'd0 |=> !redirect);
endmodule

bind pc_sequencer pcseq_checker #(
  .AW        (AW),
  .LEN_W     (LEN_W),
  .RIDX_W    (RIDX_W),
  .PC_INDEX  (PC_INDEX),
  .RESET_VEC (RESET_VEC)
) u_pcseq_checker (
  .clk       (clk),
  .rst       (rst),
  .instr_len (instr_len),
  .op_class  (op_class),
  .cond_code (cond_code),
  .reg_idx   (reg_idx),
  .dest      (dest),
  .flag_we   (flag_we),
  .flag_in   (flag_in),
  .pc        (pc),
  .redirect  (redirect),
  .flags     (flags)
);

// File: tb/test_pc_sequencer.sv
module test_pc_sequencer;
  localparam int          AW    = 32;
  localparam int          LEN_W = 4;
  localparam logic [31:0] RVEC  = 32'h0000_0200;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  instr_len = '0;
  logic [1:0]  op_class = '0;
  logic [3:0]  cond_code = '0;
  logic [3:0]  reg_idx = '0;
  logic [31:0] dest = '0;
  logic        flag_we = 1'b0;
  logic [3:0]  flag_in = '0;
  logic [31:0] pc;
  logic        redirect;
  logic [3:0]  flags;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  pc_sequencer #(.AW(AW), .LEN_W(LEN_W), .RESET_VEC(RVEC)) i_pc_sequencer (
    .clk(clk), .rst(rst), .instr_len(instr_len), .op_class(op_class),
    .cond_code(cond_code), .reg_idx(reg_idx), .dest(dest),
    .flag_we(flag_we), .flag_in(flag_in),
    .pc(pc), .redirect(redirect), .flags(flags)
  );

  // {flags NZVC, cond, expected taken}
  localparam int NV = 26;
  localparam logic [8:0] VEC [NV] = '{
    {4'b0100, 4'd0,  1'b1}, {4'b0000, 4'd0,  1'b0},
    {4'b0000, 4'd1,  1'b1}, {4'b1000, 4'd2,  1'b1},
    {4'b1010, 4'd2,  1'b1}, {4'b0010, 4'd2,  1'b0},
    {4'b0100, 4'd3,  1'b1}, {4'b0000, 4'd3,  1'b0},
    {4'b0000, 4'd4,  1'b1}, {4'b1000, 4'd4,  1'b0},
    {4'b0000, 4'd5,  1'b1}, {4'b1000, 4'd5,  1'b0},
    {4'b0100, 4'd8,  1'b1}, {4'b0100, 4'd9,  1'b0},
    {4'b0001, 4'd10, 1'b1}, {4'b1000, 4'd10, 1'b0},
    {4'b0100, 4'd11, 1'b1}, {4'b0000, 4'd11, 1'b0},
    {4'b0000, 4'd12, 1'b1}, {4'b0001, 4'd12, 1'b0},
    {4'b0000, 4'd13, 1'b1}, {4'b0001, 4'd13, 1'b0},
    {4'b1111, 4'd6,  1'b0}, {4'b1111, 4'd7,  1'b0},
    {4'b1111, 4'd14, 1'b0}, {4'b0000, 4'd15, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic [1:0] op, input logic [3:0] len, input logic [3:0] cc,
                       input logic [3:0] idx, input logic [31:0] d,
                       input logic fwe, input logic [3:0] fin);
    op_class = op; instr_len = len; cond_code = cc; reg_idx = idx;
    dest = d; flag_we = fwe; flag_in = fin;
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected <= 20000 cycles", cycles);
      finish_up();
    end
  end

  initial begin
    logic [31:0] pc_before;
    drive(2'd0, 4'd0, 4'd0, 4'd0, 32'd0, 1'b0, 4'd0);
    step(); step();
    // R1 reset state
    check("R1 pc", pc, RVEC);
    check("R1 flags", {28'd0, flags}, 32'd0);
    check("R1 redirect", {31'd0, redirect}, 32'd0);
    rst = 1'b0;

    // condition table, R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      drive(2'd0, 4'd0, 4'd0, 4'd0, 32'd0, 1'b1, VEC[i][8:5]);
      step();
      check("R9 flag load", {28'd0, flags}, {28'd0, VEC[i][8:5]});
      pc_before = pc;
      drive(2'd2, 4'd4, VEC[i][4:1], 4'd0, 32'h0000_1000 + 32'(i) * 32'h10, 1'b0, 4'd0);
      step();
      if (VEC[i][4:1] >= 4'd8)
        check(VEC[i][0] ? "R6 taken pc" : "R6/R7/R8 fallthrough pc", pc,
              VEC[i][0] ? 32'h0000_1000 + 32'(i) * 32'h10 : pc_before + 32'd4);
      else
        check(VEC[i][0] ? "R5 taken pc" : "R5/R7/R8 fallthrough pc", pc,
              VEC[i][0] ? 32'h0000_1000 + 32'(i) * 32'h10 : pc_before + 32'd4);
      check("R8 redirect", {31'd0, redirect}, {31'd0, VEC[i][0]});
    end

    // R2 sequential advance, two lengths; R10 strobe falls
    drive(2'd1, 4'd2, 4'd0, 4'd0, 32'h0000_4000, 1'b0, 4'd0);
    step();
    check("R3 jump pc", pc, 32'h0000_4000);
    check("R3 jump redirect", {31'd0, redirect}, 32'd1);
    drive(2'd0, 4'd3, 4'd0, 4'd0, 32'hDEAD_0000, 1'b0, 4'd0);
    step();
    check("R2 seq len3", pc, 32'h0000_4003);
    check("R10 strobe one cycle", {31'd0, redirect}, 32'd0);
    drive(2'd0, 4'd7, 4'd0, 4'd0, 32'd0, 1'b0, 4'd0);
    step();
    check("R2 seq len7", pc, 32'h0000_400A);

    // R10 back-to-back transfers keep strobe high
    drive(2'd1, 4'd1, 4'd0, 4'd0, 32'h0000_5000, 1'b0, 4'd0);
    step();
    drive(2'd1, 4'd1, 4'd0, 4'd0, 32'h0000_6000, 1'b0, 4'd0);
    step();
    check("R10 back-to-back pc", pc, 32'h0000_6000);
    check("R10 back-to-back redirect", {31'd0, redirect}, 32'd1);

    // R4 register writes
    drive(2'd3, 4'd5, 4'd0, 4'd5, 32'h0000_9000, 1'b0, 4'd0);
    step();
    check("R4 other reg pc", pc, 32'h0000_6005);
    check("R4 other reg redirect", {31'd0, redirect}, 32'd0);
    drive(2'd3, 4'd5, 4'd0, 4'd15, 32'h0000_9000, 1'b0, 4'd0);
    step();
    check("R4 reg15 pc", pc, 32'h0000_9000);
    check("R4 reg15 redirect", {31'd0, redirect}, 32'd1);

    // R9 flags hold without enable, same-cycle write uses old flags
    drive(2'd0, 4'd0, 4'd0, 4'd0, 32'd0, 1'b1, 4'b0000);
    step();
    drive(2'd0, 4'd1, 4'd0, 4'd0, 32'd0, 1'b0, 4'b1111);
    step();
    check("R9 flags hold", {28'd0, flags}, 32'd0);
    drive(2'd2, 4'd2, 4'd0, 4'd0, 32'h0000_A000, 1'b1, 4'b0100);
    step();
    check("R9 same-cycle uses old flags pc", pc, 32'h0000_9003);
    check("R9 same-cycle new flags", {28'd0, flags}, 32'h4);
    drive(2'd2, 4'd2, 4'd0, 4'd0, 32'h0000_A000, 1'b0, 4'd0);
    step();
    check("R9 following branch sees new flags", pc, 32'h0000_A000);

    // R1 reset mid-run
    rst = 1'b1;
    drive(2'd1, 4'd0, 4'd0, 4'd0, 32'h0000_7777, 1'b0, 4'd0);
    step();
    check("R1 mid-run pc", pc, RVEC);
    check("R1 mid-run flags", {28'd0, flags}, 32'd0);
    check("R1 mid-run redirect", {31'd0, redirect}, 32'd0);
    rst = 1'b0;
    drive(2'd0, 4'd0, 4'd0, 4'd0, 32'd0, 1'b0, 4'd0);
    step();

    finish_up();
  end
endmodule